// File: doc/BRIEF.md
# Burst Address Counter with Start-Address Rewind

This block produces the address used by a synchronous memory port on each clock cycle. A cycle can take an address from the pins and latch it as a new burst start. It can step an internal counter forward by one, leave the counter where it is, or jump straight back to the most recently latched start address. The stepped, held or rewound address is used by the access of that same cycle, so a burst runs without idle cycles. It also runs without idle cycles when it restarts from its first location.

The counter covers only the lower bits of the address. The most significant address bit bypasses the counter and always follows its input pin. A system that needs a full-depth burst therefore drives that bit itself at the half-way boundary.

For checking, the top module wraps a small behavioural memory that the address indexes modulo its depth. A parameter selects the read path: flow-through or pipelined, where pipelined adds one register stage.

Top module: `burst_addr_gen`

## Requirements
- R1: With the port selected, `rewind_n` high and `load_n` low, `addr_out` equals `addr_in` in that cycle. At the next edge, the lower `ADDR_W-1` bits of `addr_in` are stored as both the counter value and the burst start.
- R2: With the port selected, `rewind_n` and `load_n` high and `step_n` low, the lower bits of `addr_out` are the stored counter plus one, modulo 2^(ADDR_W-1). The counter takes that value at the edge. A load at An followed by two steps accesses An, An+1 and An+2.
- R3: With the port selected and all three controls high, the lower bits of `addr_out` equal the stored counter, and the counter keeps its value.
- R4: With the port selected and `rewind_n` low, the lower bits of `addr_out` equal the stored burst start, whatever `load_n` and `step_n` are. The counter takes that value, and the burst start is left unchanged.
- R5: The counter wraps from all ones (7FFFF hex for the default width) to zero. Bit `ADDR_W-1` of `addr_out` always equals bit `ADDR_W-1` of `addr_in`.
- R6: The port is selected only when `sel_n` is low and `sel` is high. While it is not selected, the counter and the burst start keep their values, whatever the controls are.
- R7: `wr_strobe` is high exactly when the port is selected and `wr_n` is low. A write stores `wdata` at `addr_out` modulo `MEM_DEPTH`.
- R8: A selected cycle with `wr_n` high reads the location at `addr_out`. With `PIPELINED` = 0 the data appears on `rdata` after the edge that ends the access cycle. With `PIPELINED` = 1 it appears one edge later.
- R9: `rst_n` low at an edge clears the counter, the burst start and the read registers to zero.
- R10: When `load_n` and `step_n` are both low and `rewind_n` is high, the load wins and the counter does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Take `addr_in` and latch it as the burst start, active low |
| step_n | input | 1 | Advance the counter by one, active low |
| rewind_n | input | 1 | Return to the latched burst start, active low |
| sel_n | input | 1 | Port select, active low half |
| sel | input | 1 | Port select, active high half |
| wr_n | input | 1 | Low for write, high for read |
| addr_in | input | ADDR_W | External address |
| wdata | input | DATA_W | Write data |
| addr_out | output | ADDR_W | Effective address of the current cycle |
| wr_strobe | output | 1 | Write taking place this cycle |
| rdata | output | DATA_W | Read data from the behavioural memory |

## Verification
The properties assume that every control and the address are driven to known levels in each cycle. They also assume that the most significant address bit is intentionally owned by the user, so it is compared with its pin rather than with any counter history. The stimulus changes inputs only on the falling edge and holds each control pattern through the following rising edge. It covers every combination of the two select pins, stacks rewind over load and load over step, and places loads just below the counter's wrap point. This keeps every cycle inside those assumptions while still reaching the priority and wrap corners.

// File: rtl/burst_pkg.sv
// Shared types for the burst address generator.
// Assumes nothing beyond a synthesizable enum.
package burst_pkg;
    // Operation applied to the counter in one cycle, after priority decode.
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_STEP   = 2'd1,
        OP_LOAD   = 2'd2,
        OP_REWIND = 2'd3
    } burst_op_e;
endpackage

// File: rtl/burst_op_decode.sv
// Turns the three active-low controls into one counter operation.
// Priority: rewind over load over step; hold when none is active.
// Assumes the controls are known levels in every cycle.
module burst_op_decode
    import burst_pkg::*;
(
    input  logic      load_n,
    input  logic      step_n,
    input  logic      rewind_n,
    output burst_op_e op
);
    // Priority encode the controls.
    always_comb begin
        if (!rewind_n)    op = OP_REWIND;
        else if (!load_n) op = OP_LOAD;
        else if (!step_n) op = OP_STEP;
        else              op = OP_HOLD;
    end
endmodule

// File: rtl/burst_counter.sv
// Lower-address counter with a saved burst-start register.
// The effective lower address (next_val) is what the current cycle accesses;
// the registers take it at the edge only while the port is selected.
// Assumes a synchronous active-low reset.
module burst_counter
    import burst_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  burst_op_e        op,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] next_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] start_q
);
    // Select the lower address used by this cycle's access.
    always_comb begin
        unique case (op)
            OP_LOAD:   next_val = load_val;
            OP_STEP:   next_val = cnt_q + 1'b1;
            OP_REWIND: next_val = start_q;
            default:   next_val = cnt_q;
        endcase
    end

    // Update the counter and the burst start while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            start_q <= '0;
        end else if (en) begin
            cnt_q <= next_val;
            if (op == OP_LOAD) start_q <= load_val;
        end
    end
endmodule

// File: rtl/burst_mem.sv
// Small behavioural single-port memory used to exercise the address path.
// Read data is registered at the access edge (flow-through) and, when
// PIPELINED is set, passed through one more register.
// Assumes the caller supplies the address already reduced to IDX_W bits.
module burst_mem #(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 64,
    parameter bit PIPELINED = 1'b1,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  logic              wr_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Write port.
    always_ff @(posedge clk) begin
        if (access && !wr_n) store[idx] <= wdata;
    end

    // Capture read data at the access edge.
    always_ff @(posedge clk) begin
        if (!rst_n)               rd_q <= '0;
        else if (access && wr_n)  rd_q <= store[idx];
    end

    generate
        if (PIPELINED) begin : g_pipe
            logic [DATA_W-1:0] pipe_q;
            // Extra output stage for pipelined timing.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= rd_q;
            end
            assign rdata = pipe_q;
        end else begin : g_flow
            assign rdata = rd_q;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
// Top: burst address generator with start-address rewind, wrapping a
// behavioural memory. The top address bit bypasses the counter.
// Assumes synchronous active-low reset and known input levels.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int MEM_DEPTH = 64,
    parameter bit PIPELINED = 1'b1,
    localparam int CNT_W    = ADDR_W - 1,
    localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              rewind_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr_out,
    output logic              wr_strobe,
    output logic [DATA_W-1:0] rdata
);
    burst_op_e        op;
    logic             access;
    logic [CNT_W-1:0] low_addr;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] start_q;

    assign access    = !sel_n && sel;
    assign wr_strobe = access && !wr_n;
    assign addr_out  = {addr_in[ADDR_W-1], low_addr};

    burst_op_decode u_dec (
        .load_n   (load_n),
        .step_n   (step_n),
        .rewind_n (rewind_n),
        .op       (op)
    );

    burst_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (access),
        .op       (op),
        .load_val (addr_in[CNT_W-1:0]),
        .next_val (low_addr),
        .cnt_q    (cnt_q),
        .start_q  (start_q)
    );

    burst_mem #(
        .DATA_W    (DATA_W),
        .DEPTH     (MEM_DEPTH),
        .PIPELINED (PIPELINED)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (access),
        .wr_n   (wr_n),
        .idx    (addr_out[IDX_W-1:0]),
        .wdata  (wdata),
        .rdata  (rdata)
    );
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Property checker for burst_addr_gen, attached by bind below.
// Assumes the inputs are known levels at each rising edge.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20,
    localparam int CNT_W = ADDR_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic              step_n,
    input logic              rewind_n,
    input logic              sel_n,
    input logic              sel,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              wr_strobe,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  start_q
);
    logic acc;
    assign acc = !sel_n && sel;

    assert_load_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && rewind_n && !load_n |-> addr_out == addr_in);
    assert_load_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && rewind_n && !load_n |=> start_q == $past(addr_in[CNT_W-1:0]));
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && rewind_n && load_n && !step_n |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
    assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && rewind_n && load_n && step_n |-> addr_out[CNT_W-1:0] == cnt_q);
    assert_hold_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && rewind_n && load_n && step_n |=> $stable(cnt_q));
    assert_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !rewind_n |-> addr_out[CNT_W-1:0] == start_q);
    assert_rewind_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !rewind_n |=> $stable(start_q));
    assert_top_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_out[ADDR_W-1] == addr_in[ADDR_W-1]);
    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(cnt_q) && $stable(start_q));
    assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe == (acc && !wr_n));
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> cnt_q == '0 && start_q == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .step_n    (step_n),
    .rewind_n  (rewind_n),
    .sel_n     (sel_n),
    .sel       (sel),
    .wr_n      (wr_n),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .wr_strobe (wr_strobe),
    .cnt_q     (cnt_q),
    .start_q   (start_q)
);

// File: tb/burst_addr_gen_test.sv
// Bench: behavioural reference model compared every clock against a
// pipelined instance (uut) and a flow-through instance (uut_ft).
module burst_addr_gen_test;
    localparam int AW = 20;
    localparam int CW = AW - 1;
    localparam int DW = 16;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          load_n = 1'b1, step_n = 1'b1, rewind_n = 1'b1;
    logic          sel_n = 1'b1, sel = 1'b0, wr_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] a_pp, a_ft;
    logic          s_pp, s_ft;
    logic [DW-1:0] r_pp, r_ft;

    burst_addr_gen #(.ADDR_W(AW), .DATA_W(DW), .MEM_DEPTH(DEPTH), .PIPELINED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .step_n(step_n), .rewind_n(rewind_n),
        .sel_n(sel_n), .sel(sel), .wr_n(wr_n), .addr_in(addr_in), .wdata(wdata),
        .addr_out(a_pp), .wr_strobe(s_pp), .rdata(r_pp));

    burst_addr_gen #(.ADDR_W(AW), .DATA_W(DW), .MEM_DEPTH(DEPTH), .PIPELINED(1'b0)) uut_ft (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .step_n(step_n), .rewind_n(rewind_n),
        .sel_n(sel_n), .sel(sel), .wr_n(wr_n), .addr_in(addr_in), .wdata(wdata),
        .addr_out(a_ft), .wr_strobe(s_ft), .rdata(r_ft));

    int errors = 0;
    int checks = 0;

    // Reference state.
    int            m_cnt, m_start;
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_ok [DEPTH];
    logic [DW-1:0] ft_exp, pp_exp;
    bit            ft_ok, pp_ok;

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: drive at falling edge, compare, then advance the model.
    task automatic cyc(string req, bit ld_n, bit st_n, bit rp_n, bit s_n, bit s,
                       bit w_n, int a, int d);
        int low;
        int eff;
        bit acc;
        @(negedge clk);
        load_n = ld_n; step_n = st_n; rewind_n = rp_n;
        sel_n = s_n; sel = s; wr_n = w_n;
        addr_in = AW'(a); wdata = DW'(d);
        #2;
        if (!rp_n)      low = m_start;
        else if (!ld_n) low = a % (1 << CW);
        else if (!st_n) low = (m_cnt + 1) % (1 << CW);
        else            low = m_cnt;
        eff = (a & (1 << CW)) | low;
        acc = !s_n && s;
        if (rst_n) begin
            check(req, "addr_out pipelined", a_pp, eff);
            check(req, "addr_out flow", a_ft, eff);
            check(req, "wr_strobe", s_pp, acc && !w_n);
            check(req, "wr_strobe flow", s_ft, acc && !w_n);
            if (ft_ok) check(req, "rdata flow", r_ft, ft_exp);
            if (pp_ok) check(req, "rdata pipelined", r_pp, pp_exp);
        end
        if (!rst_n) begin
            m_cnt = 0; m_start = 0;
            ft_exp = '0; pp_exp = '0; ft_ok = 1; pp_ok = 1;
        end else begin
            pp_exp = ft_exp; pp_ok = ft_ok;
            if (acc && w_n) begin
                ft_exp = m_mem[eff % DEPTH];
                ft_ok  = m_ok[eff % DEPTH];
            end
            if (acc && !w_n) begin
                m_mem[eff % DEPTH] = DW'(d);
                m_ok[eff % DEPTH]  = 1;
            end
            if (acc) begin
                if (rp_n && !ld_n) m_start = a % (1 << CW);
                m_cnt = low;
            end
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_ok[i] = 0;
        m_cnt = 0; m_start = 0;
        ft_exp = '0; pp_exp = '0; ft_ok = 1; pp_ok = 1;
        // R9: reset clears counter, start and read registers.
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc("R9", 1, 1, 1, 0, 1, 1, 'h12345, 0);
        rst_n = 1'b1;
        cyc("R9", 1, 1, 1, 0, 1, 1, 'h80000, 0);
        // R1 load then R2 stepping writes.
        cyc("R1", 0, 1, 1, 0, 1, 0, 'h00010, 'hA0);
        for (int i = 1; i <= 5; i++) cyc("R2", 1, 0, 1, 0, 1, 0, 'h0, 'hA0 + i);
        // R3 hold: repeated writes to one location, then read it back.
        cyc("R3", 1, 1, 1, 0, 1, 0, 'h0, 'hB0);
        cyc("R3", 1, 1, 1, 0, 1, 0, 'h0, 'hB1);
        cyc("R3", 1, 1, 1, 0, 1, 1, 'h0, 0);
        // R4 rewind with read in the same cycle, then R8 read timing.
        cyc("R4", 1, 1, 0, 0, 1, 1, 'h0, 0);
        for (int i = 0; i < 6; i++) cyc("R8", 1, 0, 1, 0, 1, 1, 'h0, 0);
        cyc("R8", 1, 1, 1, 0, 1, 1, 'h0, 0);
        cyc("R8", 1, 1, 1, 0, 1, 1, 'h0, 0);
        // R4 rewind outranks a simultaneous load and step.
        cyc("R4", 0, 0, 0, 0, 1, 1, 'h00777, 0);
        cyc("R4", 1, 1, 1, 0, 1, 1, 'h0, 0);
        // R10 load outranks step.
        cyc("R10", 0, 0, 1, 0, 1, 0, 'h00020, 'hC0);
        cyc("R10", 1, 1, 1, 0, 1, 1, 'h0, 0);
        cyc("R10", 1, 1, 1, 0, 1, 1, 'h0, 0);
        // R5 wrap of the lower counter and top bit taken from the pin.
        cyc("R5", 0, 1, 1, 0, 1, 0, 'h7FFFE, 'hD0);
        cyc("R5", 1, 0, 1, 0, 1, 0, 'h0, 'hD1);
        cyc("R5", 1, 0, 1, 0, 1, 0, 'h80000, 'hD2);
        cyc("R5", 1, 0, 1, 0, 1, 1, 'h80000, 0);
        cyc("R5", 1, 1, 0, 0, 1, 1, 'h0, 0);
        // R6 deselected cycles leave counter and start alone; R7 no strobe.
        cyc("R6", 0, 1, 1, 1, 1, 0, 'h00033, 'hE0);
        cyc("R6", 1, 0, 1, 0, 0, 0, 'h0, 'hE1);
        cyc("R7", 1, 1, 0, 1, 0, 0, 'h0, 'hE2);
        cyc("R6", 1, 1, 1, 0, 1, 1, 'h0, 0);
        cyc("R6", 1, 1, 0, 0, 1, 1, 'h0, 0);
        cyc("R6", 1, 1, 1, 0, 1, 1, 'h0, 0);
        // Mixed traffic across all controls and select combinations.
        for (int i = 0; i < 500; i++) begin
            int r = int'($urandom);
            int a = (r[3]) ? int'($urandom_range(0, 15)) + 'h7FFF0 : int'($urandom_range(0, 127));
            if (r[4]) a = a | 'h80000;
            cyc("R8", r[5] | r[6], r[7], r[8] | r[9] | r[10], r[11] & r[12], !(r[13] & r[14]),
                r[15], a, int'($urandom_range(0, 65535)));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule